// File: doc/BRIEF.md
# Sprite Cell Expander

This block turns a table of sprite attribute entries into a stream of per-cell draw commands. The table sits in a small word-addressed RAM outside the block. Each entry is four words and describes a rectangle of 16x16-pixel cells, up to eight cells wide and eight cells tall. A start pulse begins a scan. The block reads the entries from the highest index down to index zero. For every entry it emits one command per cell, carrying the screen X, screen Y, tile code, colour, both flip flags and the transparent pen value. A one-cycle done pulse ends the scan.

Flipping applies to the whole object. A horizontally flipped entry places its first column at the right edge of the rectangle, and a vertically flipped entry places its first row at the bottom. The downstream drawing stage therefore sees a mirrored object and not a grid of individually mirrored cells. Commands leave through a valid/ready handshake, so a slow drawing stage can stall the block without losing anything.

Top module: `spr_cell_expander`

## Requirements
- R1: A scan reads entries from index TABLE_WORDS/4-1 down to 0. Entry i occupies table words 4i (attributes), 4i+1 (tile code), 4i+2 (X) and 4i+3 (Y). Read data arrives one cycle after `rd_en_o`. Commands leave in entry order.
- R2: In the attribute word, the colour is bits 5:0, the horizontal flip is bit 15 and the vertical flip is bit 11. These values are copied into every command of that entry.
- R3: An entry emits exactly W*H commands. W is attribute bits 10:8 plus one and H is attribute bits 14:12 plus one, so each ranges from 1 to 8.
- R4: Cells are produced with the column index as the outer loop and the row index as the inner loop. The k-th cell of an entry (k from 0) carries tile code (word 1 + k) modulo 2^16.
- R5: A cell at column ax and row ay is placed at X + c*16 and Y + r*16, both modulo 2^16 (signed 16-bit wrap). Here c = W-1-ax when horizontal flip is set, and c = ax otherwise. Likewise r = H-1-ay when vertical flip is set, and r = ay otherwise.
- R6: Every command carries the transparent pen value given by the TRANSP_PEN parameter, which defaults to 15.
- R7: While `cmd_valid_o` is high and `cmd_ready_i` is low, the command is held unchanged. Every command is transferred exactly once, with none dropped or repeated.
- R8: `done_o` is high for exactly one cycle after the last command of entry 0 has been accepted. At that point `busy_o` and `cmd_valid_o` are low. `busy_o` is high from the cycle after a start until the done pulse.
- R9: A start pulse while `busy_o` is high is ignored. The running scan continues unchanged.
- R10: During and just after reset, `busy_o`, `done_o`, `rd_en_o` and `cmd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a scan when idle |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at the end of a scan |
| rd_en_o | output | 1 | Table read strobe |
| rd_addr_o | output | $clog2(TABLE_WORDS) | Table word address |
| rd_data_i | input | 16 | Table word, one cycle after the strobe |
| cmd_valid_o | output | 1 | Command present |
| cmd_ready_i | input | 1 | Downstream accepts the command |
| cmd_x_o | output | 16 | Cell screen X, two's complement |
| cmd_y_o | output | 16 | Cell screen Y, two's complement |
| cmd_tile_o | output | 16 | Cell tile code |
| cmd_color_o | output | 6 | Colour |
| cmd_flipx_o | output | 1 | Horizontal flip |
| cmd_flipy_o | output | 1 | Vertical flip |
| cmd_transp_o | output | PEN_W | Transparent pen value |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- A full 8x8 entry with both flips, a tile code that wraps past 0xFFFF and an X position near the negative wrap. A design that mirrored each cell instead of the object, or that reversed the loop nesting, would emit cells at swapped positions or with tile codes one row off.
- Single-flip rectangles such as 3x2 and 1x4, which catch an off-by-one in the W-1-ax mirror or a swapped bit between the two flip flags.
- A ready line held mostly low, which exposes a command that changes while stalled or is sent twice.
- A second start pulse in the middle of a scan, which would restart the walk and repeat the top entries.
- A scan made only of single-cell entries with random flips, where the flip must not move the cell at all.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int WORD_W      = 16;
    localparam int COLOR_W     = 6;
    localparam int SPAN_W      = 3;
    localparam int CELL_SHIFT  = 4;
    localparam int ENTRY_WORDS = 4;
    localparam int ENT_SEL_W   = $clog2(ENTRY_WORDS);

    // attribute word field positions
    localparam int FLIPX_BIT = 15;
    localparam int FLIPY_BIT = 11;
    localparam int WID_LSB   = 8;
    localparam int HGT_LSB   = 12;
    localparam int COLOR_LSB = 0;

    // word order inside one entry
    localparam logic [ENT_SEL_W-1:0] W_ATTR = 2'd0;
    localparam logic [ENT_SEL_W-1:0] W_TILE = 2'd1;
    localparam logic [ENT_SEL_W-1:0] W_XPOS = 2'd2;
    localparam logic [ENT_SEL_W-1:0] W_YPOS = 2'd3;

    typedef struct packed {
        logic [WORD_W-1:0]  x;
        logic [WORD_W-1:0]  y;
        logic [WORD_W-1:0]  tile;
        logic [SPAN_W-1:0]  w_m1;
        logic [SPAN_W-1:0]  h_m1;
        logic               fx;
        logic               fy;
        logic [COLOR_W-1:0] color;
    } spr_entry_t;

    typedef struct packed {
        logic [WORD_W-1:0]  x;
        logic [WORD_W-1:0]  y;
        logic [WORD_W-1:0]  tile;
        logic [COLOR_W-1:0] color;
        logic               fx;
        logic               fy;
    } spr_cmd_t;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_LOAD = 2'd1,
        SC_EMIT = 2'd2
    } scan_state_t;

endpackage

// File: rtl/spr_entry_loader.sv
module spr_entry_loader
    import spr_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = IDX_W + ENT_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [WORD_W-1:0] rd_data_i,
    output spr_entry_t        entry_o,
    output logic              loaded_o
);

    localparam logic [ENT_SEL_W-1:0] LAST_WORD = ENT_SEL_W'(ENTRY_WORDS - 1);

    typedef struct packed {
        logic                 active;
        logic [ENT_SEL_W-1:0] word;
        logic [IDX_W-1:0]     idx;
        logic                 cap_pend;
        logic [ENT_SEL_W-1:0] cap_word;
        spr_entry_t           ent;
        logic                 loaded;
    } ld_state_t;

    ld_state_t q, d;

    always_comb begin
        d         = q;
        d.loaded  = 1'b0;
        d.cap_pend = 1'b0;
        rd_en_o   = 1'b0;
        rd_addr_o = {q.idx, q.word};

        // capture the word requested in the previous cycle
        if (q.cap_pend) begin
            case (q.cap_word)
                W_ATTR: begin
                    d.ent.color = rd_data_i[COLOR_LSB +: COLOR_W];
                    d.ent.w_m1  = rd_data_i[WID_LSB +: SPAN_W];
                    d.ent.h_m1  = rd_data_i[HGT_LSB +: SPAN_W];
                    d.ent.fx    = rd_data_i[FLIPX_BIT];
                    d.ent.fy    = rd_data_i[FLIPY_BIT];
                end
                W_TILE:  d.ent.tile = rd_data_i;
                W_XPOS:  d.ent.x    = rd_data_i;
                default: d.ent.y    = rd_data_i;
            endcase
            if (q.cap_word == LAST_WORD) begin
                d.loaded = 1'b1;
            end
        end

        // issue one read per cycle across the entry
        if (q.active) begin
            rd_en_o    = 1'b1;
            d.cap_pend = 1'b1;
            d.cap_word = q.word;
            d.word     = q.word + 1'b1;
            if (q.word == LAST_WORD) begin
                d.active = 1'b0;
            end
        end

        if (load_i) begin
            d.active = 1'b1;
            d.word   = '0;
            d.idx    = idx_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign entry_o  = q.ent;
    assign loaded_o = q.loaded;

endmodule

// File: rtl/spr_cell_gen.sv
module spr_cell_gen
    import spr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  spr_entry_t entry_i,
    input  logic       ready_i,
    output logic       valid_o,
    output spr_cmd_t   cmd_o,
    output logic       busy_o
);

    typedef struct packed {
        logic              run;
        logic [SPAN_W-1:0] ax;
        logic [SPAN_W-1:0] ay;
        logic [WORD_W-1:0] tile;
        spr_entry_t        ent;
        logic              vld;
        spr_cmd_t          cmd;
    } cg_state_t;

    cg_state_t q, d;
    logic [SPAN_W-1:0] col_c;
    logic [SPAN_W-1:0] row_c;

    always_comb begin
        d     = q;
        // mirror the grid index, not the cell contents
        col_c = q.ent.fx ? (q.ent.w_m1 - q.ax) : q.ax;
        row_c = q.ent.fy ? (q.ent.h_m1 - q.ay) : q.ay;

        if (q.vld && ready_i) begin
            d.vld = 1'b0;
        end

        if (start_i) begin
            d.run  = 1'b1;
            d.ax   = '0;
            d.ay   = '0;
            d.tile = entry_i.tile;
            d.ent  = entry_i;
        end else if (q.run && (!q.vld || ready_i)) begin
            d.vld       = 1'b1;
            d.cmd.x     = q.ent.x + (WORD_W'(col_c) << CELL_SHIFT);
            d.cmd.y     = q.ent.y + (WORD_W'(row_c) << CELL_SHIFT);
            d.cmd.tile  = q.tile;
            d.cmd.color = q.ent.color;
            d.cmd.fx    = q.ent.fx;
            d.cmd.fy    = q.ent.fy;
            d.tile      = q.tile + 1'b1;
            // rows inner, columns outer
            if (q.ay == q.ent.h_m1) begin
                d.ay = '0;
                if (q.ax == q.ent.w_m1) begin
                    d.run = 1'b0;
                end else begin
                    d.ax = q.ax + 1'b1;
                end
            end else begin
                d.ay = q.ay + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign valid_o = q.vld;
    assign cmd_o   = q.cmd;
    assign busy_o  = q.run || q.vld;

endmodule

// File: rtl/spr_cell_expander.sv
module spr_cell_expander
    import spr_pkg::*;
#(
    parameter int TABLE_WORDS = 1024,
    parameter int TRANSP_PEN  = 15,
    parameter int PEN_W       = 4,
    localparam int ENTRIES    = TABLE_WORDS / ENTRY_WORDS,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int ADDR_W     = $clog2(TABLE_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               rd_en_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    input  logic [WORD_W-1:0]  rd_data_i,
    output logic               cmd_valid_o,
    input  logic               cmd_ready_i,
    output logic [WORD_W-1:0]  cmd_x_o,
    output logic [WORD_W-1:0]  cmd_y_o,
    output logic [WORD_W-1:0]  cmd_tile_o,
    output logic [COLOR_W-1:0] cmd_color_o,
    output logic               cmd_flipx_o,
    output logic               cmd_flipy_o,
    output logic [PEN_W-1:0]   cmd_transp_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        scan_state_t      st;
        logic [IDX_W-1:0] idx;
        logic             done;
    } top_state_t;

    top_state_t q, d;

    logic             load_c;
    logic [IDX_W-1:0] load_idx_c;
    logic             gen_start_c;
    logic             loaded;
    logic             gen_busy;
    spr_entry_t       entry;
    spr_cmd_t         cmd;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        load_c      = 1'b0;
        load_idx_c  = q.idx;
        gen_start_c = 1'b0;
        case (q.st)
            SC_IDLE: begin
                if (start_i) begin
                    d.st       = SC_LOAD;
                    d.idx      = TOP_IDX;
                    load_c     = 1'b1;
                    load_idx_c = TOP_IDX;
                end
            end
            SC_LOAD: begin
                if (loaded) begin
                    d.st        = SC_EMIT;
                    gen_start_c = 1'b1;
                end
            end
            SC_EMIT: begin
                if (!gen_busy) begin
                    if (q.idx == '0) begin
                        d.st   = SC_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.idx      = q.idx - 1'b1;
                        d.st       = SC_LOAD;
                        load_c     = 1'b1;
                        load_idx_c = q.idx - 1'b1;
                    end
                end
            end
            default: d.st = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: SC_IDLE, idx: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    spr_entry_loader #(
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_c),
        .idx_i     (load_idx_c),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o),
        .rd_data_i (rd_data_i),
        .entry_o   (entry),
        .loaded_o  (loaded)
    );

    spr_cell_gen u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (gen_start_c),
        .entry_i (entry),
        .ready_i (cmd_ready_i),
        .valid_o (cmd_valid_o),
        .cmd_o   (cmd),
        .busy_o  (gen_busy)
    );

    assign busy_o       = (q.st != SC_IDLE);
    assign done_o       = q.done;
    assign cmd_x_o      = cmd.x;
    assign cmd_y_o      = cmd.y;
    assign cmd_tile_o   = cmd.tile;
    assign cmd_color_o  = cmd.color;
    assign cmd_flipx_o  = cmd.fx;
    assign cmd_flipy_o  = cmd.fy;
    assign cmd_transp_o = PEN_W'(TRANSP_PEN);

endmodule

// File: rtl/spr_cell_expander_chk.sv
module spr_cell_expander_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        rd_en_o,
    input logic        cmd_valid_o,
    input logic        cmd_ready_i,
    input logic [15:0] cmd_x_o,
    input logic [15:0] cmd_y_o,
    input logic [15:0] cmd_tile_o,
    input logic [5:0]  cmd_color_o,
    input logic        cmd_flipx_o,
    input logic        cmd_flipy_o
);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o &&
        $stable({cmd_x_o, cmd_y_o, cmd_tile_o, cmd_color_o, cmd_flipx_o, cmd_flipy_o}));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !cmd_valid_o);

    assert_cmd_in_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> busy_o);

    assert_read_in_scan_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> busy_o);

    assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

endmodule

bind spr_cell_expander spr_cell_expander_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rd_en_o     (rd_en_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_x_o     (cmd_x_o),
    .cmd_y_o     (cmd_y_o),
    .cmd_tile_o  (cmd_tile_o),
    .cmd_color_o (cmd_color_o),
    .cmd_flipx_o (cmd_flipx_o),
    .cmd_flipy_o (cmd_flipy_o)
);

// File: tb/spr_cell_expander_bench.sv
module spr_cell_expander_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, start, ready;
    logic        busy, done, rd_en, valid;
    logic [9:0]  rd_addr;
    logic [15:0] rd_data;
    logic [15:0] cx, cy, ctile;
    logic [5:0]  ccolor;
    logic        cfx, cfy;
    logic [3:0]  ctransp;

    int errors = 0;
    int checks = 0;

    logic [15:0] mem [0:1023];
    bit   [59:0] expq [$];

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    spr_cell_expander u_spr_cell_expander (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .cmd_valid_o(valid), .cmd_ready_i(ready),
        .cmd_x_o(cx), .cmd_y_o(cy), .cmd_tile_o(ctile), .cmd_color_o(ccolor),
        .cmd_flipx_o(cfx), .cmd_flipy_o(cfy), .cmd_transp_o(ctransp)
    );

    task automatic check(input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // expected command list from R1..R6
    function automatic void build_expected();
        expq.delete();
        for (int e = 255; e >= 0; e--) begin
            logic [15:0] a;
            int w, h, k;
            a = mem[4*e];
            w = int'(a[10:8]) + 1;
            h = int'(a[14:12]) + 1;
            k = 0;
            for (int ax = 0; ax < w; ax++) begin
                for (int ay = 0; ay < h; ay++) begin
                    int c, r;
                    logic [15:0] px, py, t;
                    c  = a[15] ? (w - 1 - ax) : ax;
                    r  = a[11] ? (h - 1 - ay) : ay;
                    px = mem[4*e+2] + 16'(c * 16);
                    py = mem[4*e+3] + 16'(r * 16);
                    t  = mem[4*e+1] + 16'(k);
                    expq.push_back({px, py, t, a[5:0], a[15], a[11], 4'd15});
                    k++;
                end
            end
        end
    endfunction

    task automatic fill_random(input bit single);
        for (int i = 0; i < 1024; i++) mem[i] = 16'($urandom);
        if (single) begin
            for (int e = 0; e < 256; e++) mem[4*e] = mem[4*e] & 16'h88FF;
        end
    endtask

    task automatic fill_directed();
        fill_random(1'b0);
        // entry scanned first: 8x8, both flips, tile wrap, X near negative wrap
        mem[1020] = 16'h8000 | 16'h0800 | 16'h7000 | 16'h0700 | 16'h002A;
        mem[1021] = 16'hFFF0;
        mem[1022] = 16'hFFF8;
        mem[1023] = 16'h7FF0;
        // entry 0: 3 wide, 2 tall, horizontal flip only
        mem[0] = 16'h8000 | 16'h1000 | 16'h0200 | 16'h0005;
        mem[1] = 16'h0100; mem[2] = 16'h0040; mem[3] = 16'h0020;
        // entry 2: 1 wide, 4 tall, vertical flip only
        mem[8] = 16'h0800 | 16'h3000 | 16'h0011;
        mem[9] = 16'h0200; mem[10] = 16'hFFE0; mem[11] = 16'h0000;
    endtask

    task automatic run_scan(input int mode, input bit restart, input string tag);
        int  cyc;
        bit  fin;
        bit [59:0] got, e;
        cyc = 0;
        fin = 1'b0;
        build_expected();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!fin) begin
            @(negedge clk);
            cyc++;
            start = restart && (cyc == 40);
            case (mode)
                0:       ready = ($urandom % 10) < 7;
                1:       ready = 1'b1;
                default: ready = ($urandom % 10) < 2;
            endcase
            #1;
            if (restart && cyc == 42)
                check(busy, {tag, " R9 busy after mid-scan start"}, 64'(busy), 64'd1);
            if (valid && ready) begin
                got = {cx, cy, ctile, ccolor, cfx, cfy, ctransp};
                if (expq.size() == 0) begin
                    check(1'b0, {tag, " R7 extra command"}, 64'(got), 64'd0);
                end else begin
                    e = expq.pop_front();
                    check(got == e, {tag, " R1 R2 R4 R5 R6 cell"}, 64'(got), 64'(e));
                end
            end
            if (done) begin
                fin = 1'b1;
                check(expq.size() == 0, {tag, " R3 R7 R9 remaining cells"},
                      64'(expq.size()), 64'd0);
                check(!busy && !valid, {tag, " R8 idle at done"},
                      64'({busy, valid}), 64'd0);
            end
            if (cyc > 60000) begin
                check(1'b0, {tag, " R8 watchdog expired"}, 64'(cyc), 64'd60000);
                fin = 1'b1;
            end
        end
        start = 1'b0;
        ready = 1'b0;
        @(negedge clk);
        #1;
        check(!done, {tag, " R8 done lasts one cycle"}, 64'(done), 64'd0);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 1'b0;
        start = 1'b0;
        ready = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (5) @(negedge clk);
        #1;
        check({busy, done, rd_en, valid} == 4'b0, "R10 outputs in reset",
              64'({busy, done, rd_en, valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check({busy, done, rd_en, valid} == 4'b0, "R10 outputs after reset",
              64'({busy, done, rd_en, valid}), 64'd0);

        fill_directed();
        run_scan(0, 1'b0, "directed");
        fill_random(1'b0);
        run_scan(1, 1'b1, "restart");
        fill_random(1'b0);
        run_scan(2, 1'b0, "stall");
        fill_random(1'b1);
        run_scan(0, 1'b0, "single R3");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule